// File: doc/BRIEF.md
# USB Host Frame Scheduler Registers

This block is the timing and control core of a simple USB host controller. It holds the software-visible control state behind a 16-bit register bus that uses byte offsets. That state covers the command word, the status flags, the interrupt enables, the current frame index, the frame list base address and a start-of-frame trim.

While the schedule runs, a free-running interval counter divides the clock into frames. At the end of each frame it advances an 11-bit frame index and emits a one-cycle start-of-frame strobe. The frame length is a fixed base count (parameter `BASE_CNT`, default 11936) plus the 7-bit trim.

Other host logic reports completion, error, resume and fault events on a five-bit event input. The block latches these events as sticky status flags, which software clears by writing 1 to them. A level interrupt is formed from the first three flags, gated by the enables.

Top module: `usb_frame_ctrl`

## Requirements
- R1: After reset the register reads are: command 0x0000, status 0x0020, enable 0x0000, frame number 0x0000, base low and base high 0x0000, trim 0x0040. `irq_o` and `sof_o` are both low.
- R2: Command (offset 0x0) stores bits 7:0 and reads bits 15:8 as zero. Bit 0 is run, bit 2 is global reset, bit 3 is suspend, bit 4 is force resume, bit 5 is debug, bit 6 is configured, and bit 7 is max packet (0 = 32 bytes, 1 = 64 bytes).
- R3: Frame number (offset 0x6) is written and read in bits 10:0. Bits 15:11 read as zero.
- R4: The frame list base is split across two offsets: 0x8 holds address bits 15:0 and 0xA holds bits 31:16. Address bits 11:0 always read as zero.
- R5: Trim (offset 0xC) stores 7 bits (6:0). While run is set, `sof_o` pulses once every `BASE_CNT` + trim clock cycles.
- R6: A frame end with run set increments the frame index modulo 2048, and `sof_o` is high for exactly one cycle. While run is clear, the index holds and no `sof_o` occurs.
- R7: Status bit 5 (halted) reads 1 while run is 0. It drops on the cycle after run is set and returns on the cycle after run is cleared.
- R8: Event input bit i (0 = transfer interrupt, 1 = error interrupt, 2 = resume, 3 = bus error, 4 = process error) sets status bit i. Writing 1 to status bits 4:0 at offset 0x2 clears them. An event in the same cycle as a clear of its bit wins, so the bit stays 1.
- R9: Enable (offset 0x4) stores bits 3:0: bit 0 timeout/CRC, bit 1 resume, bit 2 on-complete, bit 3 short packet. `irq_o` is high when status bit 0 is set with enable bit 2 or 3, or status bit 1 with enable bit 0, or status bit 2 with enable bit 1. Status bits 3 and 4 never drive `irq_o`.
- R10: Writing command bit 1 returns every register to its R1 value on the next cycle, with command reading 0x0002. Command bit 1 clears itself one cycle later.
- R11: Offsets 0xE and above read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 4 | Register byte offset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i`, combinational |
| evt_i | input | 5 | Status event strobes, bit i sets status bit i |
| irq_o | output | 1 | Level interrupt |
| sof_o | output | 1 | One-cycle start-of-frame strobe |

## Verification
The clash that matters is a software write-1-to-clear on a status flag landing in the same cycle as a hardware event setting that same flag. The bench first sets the error flag through the event input. In a single cycle it then raises that event again and writes 1 to the same bit, and the flag must still read 1 afterwards. A lone clear in the next step must then drop it, which shows that the write path itself works. Frame timing is judged separately by counting cycles between strobes, both from a rollover at index 2047 and after a change of the trim.

// File: rtl/usb_fc_pkg.sv
package usb_fc_pkg;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned IDX_W   = 11;
  localparam int unsigned TRIM_W  = 7;
  localparam int unsigned EVT_W   = 5;
  localparam int unsigned EN_W    = 4;
  localparam logic [TRIM_W-1:0] TRIM_DEF = 7'd64;

  localparam logic [ADDR_W-1:0] OFS_CMD     = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_STS     = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_EN      = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_FRNUM   = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_BASE_LO = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_BASE_HI = 4'hA;
  localparam logic [ADDR_W-1:0] OFS_TRIM    = 4'hC;

  localparam int unsigned CMD_RUN  = 0;
  localparam int unsigned CMD_HCRST = 1;

  // enable bit positions
  localparam int unsigned EN_TOCRC  = 0;
  localparam int unsigned EN_RESUME = 1;
  localparam int unsigned EN_IOC    = 2;
  localparam int unsigned EN_SHORT  = 3;
endpackage

// File: rtl/usb_fc_regs.sv
module usb_fc_regs
  import usb_fc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hc_rst_o,
  output logic [7:0]        cmd_o,
  output logic [EN_W-1:0]   en_o,
  output logic [31:0]       base_o,
  output logic [TRIM_W-1:0] trim_o
);
  logic [7:0]        cmd_q;
  logic [EN_W-1:0]   en_q;
  logic [3:0]        base_lo_q;
  logic [15:0]       base_hi_q;
  logic [TRIM_W-1:0] trim_q;

  assign hc_rst_o = wr_i && (addr_i == OFS_CMD) && wdata_i[CMD_HCRST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      en_q      <= '0;
      base_lo_q <= '0;
      base_hi_q <= '0;
      trim_q    <= TRIM_DEF;
    end else begin
      if (cmd_q[CMD_HCRST]) cmd_q[CMD_HCRST] <= 1'b0;
      if (hc_rst_o) begin
        cmd_q     <= 8'h02;
        en_q      <= '0;
        base_lo_q <= '0;
        base_hi_q <= '0;
        trim_q    <= TRIM_DEF;
      end else if (wr_i) begin
        unique case (addr_i)
          OFS_CMD:     cmd_q     <= {wdata_i[7:2], 1'b0, wdata_i[0]};
          OFS_EN:      en_q      <= wdata_i[EN_W-1:0];
          OFS_BASE_LO: base_lo_q <= wdata_i[15:12];
          OFS_BASE_HI: base_hi_q <= wdata_i;
          OFS_TRIM:    trim_q    <= wdata_i[TRIM_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign cmd_o  = cmd_q;
  assign en_o   = en_q;
  assign base_o = {base_hi_q, base_lo_q, 12'h000};
  assign trim_o = trim_q;
endmodule

// File: rtl/usb_fc_status.sv
module usb_fc_status
  import usb_fc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hc_rst_i,
  input  logic             run_i,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             clr_wr_i,
  input  logic [EVT_W-1:0] clr_mask_i,
  input  logic [EN_W-1:0]  en_i,
  output logic [5:0]       sts_o,
  output logic             irq_o
);
  logic [EVT_W-1:0] flag_q;
  logic             halted_q;
  logic [EVT_W-1:0] clr;

  assign clr = clr_wr_i ? clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q   <= '0;
      halted_q <= 1'b1;
    end else if (hc_rst_i) begin
      flag_q   <= '0;
      halted_q <= 1'b1;
    end else begin
      flag_q   <= (flag_q & ~clr) | evt_i;  // event beats clear
      halted_q <= ~run_i;
    end
  end

  assign sts_o = {halted_q, flag_q};
  assign irq_o = (flag_q[0] & (en_i[EN_IOC] | en_i[EN_SHORT]))
               | (flag_q[1] & en_i[EN_TOCRC])
               | (flag_q[2] & en_i[EN_RESUME]);
endmodule

// File: rtl/usb_fc_frame.sv
module usb_fc_frame
  import usb_fc_pkg::*;
#(
  parameter int unsigned BASE_CNT = 11936
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hc_rst_i,
  input  logic              run_i,
  input  logic [TRIM_W-1:0] trim_i,
  input  logic              idx_wr_i,
  input  logic [IDX_W-1:0]  idx_wdata_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              sof_o
);
  localparam int unsigned MAX_PER = BASE_CNT + (1 << TRIM_W) - 1;
  localparam int unsigned CNT_W   = $clog2(MAX_PER + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic [IDX_W-1:0] idx_q;
  logic             sof_q;
  logic             tick;

  assign last = CNT_W'(BASE_CNT) + CNT_W'(trim_i) - CNT_W'(1);
  // >= keeps a shortened period from overrunning the counter
  assign tick = run_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
      sof_q <= 1'b0;
    end else if (hc_rst_i) begin
      cnt_q <= '0;
      idx_q <= '0;
      sof_q <= 1'b0;
    end else begin
      sof_q <= tick;
      if (!run_i || tick) cnt_q <= '0;
      else                cnt_q <= cnt_q + CNT_W'(1);
      if (idx_wr_i)  idx_q <= idx_wdata_i;
      else if (tick) idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign idx_o = idx_q;
  assign sof_o = sof_q;
endmodule

// File: rtl/usb_frame_ctrl.sv
module usb_frame_ctrl
  import usb_fc_pkg::*;
#(
  parameter int unsigned BASE_CNT = 11936
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [EVT_W-1:0]  evt_i,
  output logic              irq_o,
  output logic              sof_o
);
  logic              hc_rst;
  logic [7:0]        cmd_w;
  logic [EN_W-1:0]   en_w;
  logic [31:0]       base_w;
  logic [TRIM_W-1:0] trim_w;
  logic [5:0]        sts_w;
  logic [IDX_W-1:0]  idx_w;
  logic              sts_wr;
  logic              idx_wr;

  assign sts_wr = bus_wr_i && (bus_addr_i == OFS_STS);
  assign idx_wr = bus_wr_i && (bus_addr_i == OFS_FRNUM);

  usb_fc_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .hc_rst_o (hc_rst),
    .cmd_o    (cmd_w),
    .en_o     (en_w),
    .base_o   (base_w),
    .trim_o   (trim_w)
  );

  usb_fc_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hc_rst_i   (hc_rst),
    .run_i      (cmd_w[CMD_RUN]),
    .evt_i      (evt_i),
    .clr_wr_i   (sts_wr),
    .clr_mask_i (bus_wdata_i[EVT_W-1:0]),
    .en_i       (en_w),
    .sts_o      (sts_w),
    .irq_o      (irq_o)
  );

  usb_fc_frame #(.BASE_CNT(BASE_CNT)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hc_rst_i    (hc_rst),
    .run_i       (cmd_w[CMD_RUN]),
    .trim_i      (trim_w),
    .idx_wr_i    (idx_wr),
    .idx_wdata_i (bus_wdata_i[IDX_W-1:0]),
    .idx_o       (idx_w),
    .sof_o       (sof_o)
  );

  always_comb begin
    unique case (bus_addr_i)
      OFS_CMD:     bus_rdata_o = DATA_W'(cmd_w);
      OFS_STS:     bus_rdata_o = DATA_W'(sts_w);
      OFS_EN:      bus_rdata_o = DATA_W'(en_w);
      OFS_FRNUM:   bus_rdata_o = DATA_W'(idx_w);
      OFS_BASE_LO: bus_rdata_o = base_w[15:0];
      OFS_BASE_HI: bus_rdata_o = base_w[31:16];
      OFS_TRIM:    bus_rdata_o = DATA_W'(trim_w);
      default:     bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/usb_frame_ctrl_chk.sv
module usb_frame_ctrl_chk
  import usb_fc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hc_rst_i,
  input logic             run_i,
  input logic             hcr_bit_i,
  input logic             idx_wr_i,
  input logic [IDX_W-1:0] idx_i,
  input logic             sof_i,
  input logic [5:0]       sts_i,
  input logic [EVT_W-1:0] evt_i,
  input logic             irq_i
);
  assert_halt_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !hc_rst_i |=> !sts_i[5]);
  assert_halt_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> sts_i[5]);
  assert_sof_needs_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sof_i) |-> $past(run_i));
  assert_sof_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> !sof_i);
  assert_idx_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !idx_wr_i && !hc_rst_i |=> $stable(idx_i));
  assert_idx_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !idx_wr_i && !hc_rst_i ##1 sof_i |-> idx_i == $past(idx_i) + IDX_W'(1));
  assert_irq_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (sts_i[2:0] != 3'b000));
  assert_hcr_selfclear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcr_bit_i && !hc_rst_i |=> !hcr_bit_i);
  assert_hcr_sets_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hc_rst_i |=> hcr_bit_i && sts_i[5] && !sof_i);

  for (genvar i = 0; i < EVT_W; i++) begin : g_evt
    assert_evt_sticks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] && !hc_rst_i |=> sts_i[i]);
  end
endmodule

bind usb_frame_ctrl usb_frame_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hc_rst_i  (hc_rst),
  .run_i     (cmd_w[0]),
  .hcr_bit_i (cmd_w[1]),
  .idx_wr_i  (idx_wr),
  .idx_i     (idx_w),
  .sof_i     (sof_o),
  .sts_i     (sts_w),
  .evt_i     (evt_i),
  .irq_i     (irq_o)
);

// File: tb/usb_frame_ctrl_test.sv
`timescale 1ns/1ps
module usb_frame_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [4:0]  evt = '0;
  logic        irq, sof;
  int          errors = 0;
  int          checks = 0;
  logic [15:0] v;

  always #4 clk = ~clk;  // 125 MHz

  usb_frame_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .evt_i(evt),
    .irq_o(irq), .sof_o(sof)
  );

  // {req, addr, wdata, expected readback}
  localparam int NV = 14;
  localparam logic [43:0] VEC [NV] = '{
    {8'd2,  4'h0, 16'hFFF8, 16'h00F8},  // R2 upper byte dropped
    {8'd2,  4'h0, 16'h0084, 16'h0084},  // R2 max packet + global reset
    {8'd2,  4'h0, 16'h0000, 16'h0000},  // R2
    {8'd9,  4'h4, 16'hFFFF, 16'h000F},  // R9 enable width
    {8'd9,  4'h4, 16'h0000, 16'h0000},  // R9
    {8'd3,  4'h6, 16'hFFFF, 16'h07FF},  // R3
    {8'd3,  4'h6, 16'h0123, 16'h0123},  // R3
    {8'd4,  4'h8, 16'hFFFF, 16'hF000},  // R4 low 12 dropped
    {8'd4,  4'hA, 16'hABCD, 16'hABCD},  // R4
    {8'd5,  4'hC, 16'hFFFF, 16'h007F},  // R5
    {8'd5,  4'hC, 16'h0005, 16'h0005},  // R5
    {8'd8,  4'h2, 16'hFFFF, 16'h0020},  // R8 clear with nothing set
    {8'd11, 4'hE, 16'hFFFF, 16'h0000},  // R11
    {8'd11, 4'hF, 16'h1234, 16'h0000}   // R11
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_now(input logic [3:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); rd_now(a, d);
  endtask

  task automatic pulse_evt(input logic [4:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] idx0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(4'h0, v); chk("R1 cmd", v, 16'h0000);
    rd_now(4'h2, v); chk("R1 sts", v, 16'h0020);
    @(negedge clk);
    rd_now(4'h4, v); chk("R1 en", v, 16'h0000);
    rd_now(4'h6, v); chk("R1 frnum", v, 16'h0000);
    @(negedge clk);
    rd_now(4'h8, v); chk("R1 base_lo", v, 16'h0000);
    rd_now(4'hA, v); chk("R1 base_hi", v, 16'h0000);
    @(negedge clk);
    rd_now(4'hC, v); chk("R1 trim", v, 16'h0040);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 sof", {15'b0, sof}, 16'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr_reg(VEC[i][35:32], VEC[i][31:16]);
      rd_reg(VEC[i][35:32], v);
      chk($sformatf("R%0d vec%0d", VEC[i][43:36], i), v, VEC[i][15:0]);
    end
    // R11: unmapped writes left the mapped registers alone
    rd_reg(4'hA, v); chk("R11 base_hi intact", v, 16'hABCD);

    // R7 halted tracks run
    wr_reg(4'h0, 16'h0001);
    rd_now(4'h2, v); chk("R7 halted one cycle after run write", v, 16'h0020);
    rd_reg(4'h2, v); chk("R7 halted dropped", v, 16'h0000);
    wr_reg(4'h0, 16'h0000);
    rd_now(4'h2, v); chk("R7 still running view", v, 16'h0000);
    rd_reg(4'h2, v); chk("R7 halted back", v, 16'h0020);

    // R8 events, W1C, concurrent set/clear
    pulse_evt(5'b11111);
    rd_reg(4'h2, v); chk("R8 all flags", v, 16'h003F);
    wr_reg(4'h2, 16'h0015);
    rd_reg(4'h2, v); chk("R8 partial clear", v, 16'h002A);
    @(negedge clk); addr = 4'h2; wdata = 16'h0002; wr = 1'b1; evt = 5'b00010;
    @(negedge clk); wr = 1'b0; evt = '0;
    rd_reg(4'h2, v); chk("R8 event beats clear", v, 16'h002A);
    wr_reg(4'h2, 16'h0002);
    rd_reg(4'h2, v); chk("R8 lone clear", v, 16'h0028);
    wr_reg(4'h2, 16'h001F);

    // R9 interrupt mapping
    pulse_evt(5'b00001);
    @(negedge clk); chk("R9 flag0 en=0", {15'b0, irq}, 16'h0);
    wr_reg(4'h4, 16'h0004); chk("R9 flag0 ioc", {15'b0, irq}, 16'h1);
    wr_reg(4'h4, 16'h0008); chk("R9 flag0 short", {15'b0, irq}, 16'h1);
    wr_reg(4'h4, 16'h0003); chk("R9 flag0 wrong en", {15'b0, irq}, 16'h0);
    wr_reg(4'h2, 16'h001F);
    pulse_evt(5'b11000);
    wr_reg(4'h4, 16'h000F); chk("R9 flags3/4 no irq", {15'b0, irq}, 16'h0);
    wr_reg(4'h2, 16'h001F);
    pulse_evt(5'b00010);
    wr_reg(4'h4, 16'h0001); chk("R9 flag1 tocrc", {15'b0, irq}, 16'h1);
    wr_reg(4'h4, 16'h0002); chk("R9 flag1 wrong en", {15'b0, irq}, 16'h0);
    wr_reg(4'h2, 16'h001F);
    pulse_evt(5'b00100);
    @(negedge clk); chk("R9 flag2 resume", {15'b0, irq}, 16'h1);
    wr_reg(4'h2, 16'h001F);
    @(negedge clk); chk("R9 cleared", {15'b0, irq}, 16'h0);

    // R10 host controller reset
    wr_reg(4'h4, 16'h000F);
    wr_reg(4'h6, 16'h0055);
    wr_reg(4'hC, 16'h0011);
    pulse_evt(5'b01000);
    wr_reg(4'h0, 16'h00FB);
    rd_now(4'h0, v); chk("R10 cmd bit1 set", v, 16'h0002);
    rd_reg(4'h0, v); chk("R10 cmd self-clear", v, 16'h0000);
    rd_now(4'h2, v); chk("R10 sts", v, 16'h0020);
    @(negedge clk);
    rd_now(4'h4, v); chk("R10 en", v, 16'h0000);
    rd_now(4'h6, v); chk("R10 frnum", v, 16'h0000);
    @(negedge clk);
    rd_now(4'hA, v); chk("R10 base_hi", v, 16'h0000);
    rd_now(4'hC, v); chk("R10 trim", v, 16'h0040);

    // R5/R6 frame timing and rollover
    wr_reg(4'h6, 16'h07FF);
    wr_reg(4'hC, 16'h0000);
    wr_reg(4'h0, 16'h0001);
    n = 0;
    do begin @(negedge clk); n++; end while (!sof && n < 20000);
    chk("R5 period trim=0", 16'(n), 16'(11936));
    rd_now(4'h6, v); chk("R6 rollover", v, 16'h0000);
    @(negedge clk); chk("R6 single pulse", {15'b0, sof}, 16'h0);
    wr_reg(4'hC, 16'h007F);
    n = 3;  // edges since the strobe, including the trim write
    do begin @(negedge clk); n++; end while (!sof && n < 20000);
    chk("R5 period trim=127", 16'(n), 16'(12063));
    rd_now(4'h6, v); chk("R6 increment", v, 16'h0001);
    wr_reg(4'h0, 16'h0000);
    rd_reg(4'h6, idx0);
    n = 0;
    for (int k = 0; k < 13000; k++) begin
      @(negedge clk);
      if (sof) n++;
    end
    chk("R6 no sof while stopped", 16'(n), 16'h0);
    rd_now(4'h6, v); chk("R6 index held", v, idx0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule